// File: doc/BRIEF.md
# Machine State Register Exception Controller

This block holds the 32-bit machine state word of a processor core, together with the save/restore copy that goes with it. Software can load the word through a write port. When the core takes an exception, the block copies the word into the save register and applies the mode changes that belong to exception entry. A return-from-interrupt strobe loads the word back from the save register. The individual mode bits are brought out as separate outputs. One combinational output tells the core whether a pending asynchronous request (external, system-management or decrementer) may be taken at this point.

Architectural bit n (0 is the most significant bit) sits at vector index 31-n. Not every reserved bit survives an exception. Bits 0 and 5–9 go through to the save register. Bits 1–4 and 10–12 are dropped on the way into it. Exception vectoring, the program counter and address translation are handled elsewhere.

Top module: `msr_exc_ctrl`

## Requirements
- R1: While reset is held, and after it is released, the state word reads 0x0000_1000: only the machine-check enable, bit 19, is set. The save register reads zero.
- R2: A write on the software port loads mtData into the state word at the next clock edge. The write is accepted when the power-mode bit (bit 13) is unchanged, or when the power-mode bit is the only bit that changes.
- R3: On exception entry, the save register receives the state word as it was before entry, with reserved bits 1–4 and 10–12 forced to zero. Every other bit is kept, including reserved bits 0 and 5–9.
- R4: On exception entry, bit 31 (little-endian) takes the old value of bit 15 (exception endianness). Bits 16, 17, 18, 26 and 27 (interrupt enable, problem state, float available, instruction and data translation) are cleared. All other bits, ME (19), ILE (15), IP (25) and POW (13) among them, keep their values.
- R5: On exception entry with cause code 1 (instruction TLB miss), 2 (data read TLB miss) or 3 (data write TLB miss), register-remap bit 14 is set. With any other cause code, bit 14 keeps its value.
- R6: A return-from-interrupt loads the state word from the save register at the next edge, with bit 14 forced to 0 and bit 13 kept at its current value. The save register does not change.
- R7: intTake is high exactly when bit 16 is 1 and at least one of extReq, smiReq and decReq is high.
- R8: A write that changes bit 13 and also any other bit is ignored. wrErr is then high for exactly the one cycle after that write.
- R9: When strobes arrive in the same cycle, exception entry wins over return-from-interrupt, and both win over a software write. A write that loses in this way leaves the state unchanged and does not raise wrErr.
- R10: Bit 13 changes only through an accepted software write. Exception entry and return-from-interrupt never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mtWr | input | 1 | Software write strobe |
| mtData | input | 32 | Software write data |
| excTake | input | 1 | Exception entry strobe |
| excCause | input | CAUSE_W | Exception cause code |
| rfi | input | 1 | Return-from-interrupt strobe |
| extReq | input | 1 | External interrupt request |
| smiReq | input | 1 | System-management interrupt request |
| decReq | input | 1 | Decrementer interrupt request |
| msrQ | output | 32 | Current state word |
| srrQ | output | 32 | Save/restore register |
| powQ | output | 1 | Power-mode enable (bit 13) |
| tgprQ | output | 1 | Register remap active (bit 14) |
| leQ | output | 1 | Little-endian mode (bit 31) |
| eeQ | output | 1 | Interrupt enable (bit 16) |
| prQ | output | 1 | Problem state (bit 17) |
| irQ | output | 1 | Instruction translation (bit 26) |
| drQ | output | 1 | Data translation (bit 27) |
| intTake | output | 1 | Gated interrupt-take |
| wrErr | output | 1 | One-cycle rejected-write flag |

## Verification
The bench builds the block with its default three-bit cause code. With that width it can sweep all eight cause codes against 64 arithmetic bit patterns, each followed by a return, so every reserved and mode bit is seen in both states across entry and restore. All eight request combinations are checked with the enable bit both set and cleared. Accepted and rejected power-mode writes are exercised, and so are all strobe collisions.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int MSR_W = 32;

  function automatic int bitIdx(input int archBit);
    return MSR_W - 1 - archBit;
  endfunction

  localparam int POW_B  = MSR_W - 1 - 13;
  localparam int TGPR_B = MSR_W - 1 - 14;
  localparam int ILE_B  = MSR_W - 1 - 15;
  localparam int EE_B   = MSR_W - 1 - 16;
  localparam int PR_B   = MSR_W - 1 - 17;
  localparam int FP_B   = MSR_W - 1 - 18;
  localparam int ME_B   = MSR_W - 1 - 19;
  localparam int IP_B   = MSR_W - 1 - 25;
  localparam int IR_B   = MSR_W - 1 - 26;
  localparam int DR_B   = MSR_W - 1 - 27;
  localparam int LE_B   = MSR_W - 1 - 31;

  // reserved bits that are dropped when the word is saved
  function automatic logic [MSR_W-1:0] dropMask();
    logic [MSR_W-1:0] m;
    m = '0;
    for (int n = 0; n < MSR_W; n++)
      if ((n >= 1 && n <= 4) || (n >= 10 && n <= 12)) m[bitIdx(n)] = 1'b1;
    return m;
  endfunction

  localparam logic [MSR_W-1:0] SAVE_MASK = ~dropMask();
  localparam logic [MSR_W-1:0] POW_MASK  = MSR_W'(1) << POW_B;
  localparam logic [MSR_W-1:0] RESET_VAL = MSR_W'(1) << ME_B;

  typedef struct packed {
    logic doExc;
    logic doRfi;
    logic doWr;
    logic tlbMiss;
  } msrCtl_t;
endpackage

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
#(
  parameter int CAUSE_W   = 3,
  parameter int ITLB_CODE = 1,
  parameter int DLD_CODE  = 2,
  parameter int DST_CODE  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               mtWr,
  input  logic [MSR_W-1:0]   mtData,
  input  logic               excTake,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic               rfi,
  input  logic               extReq,
  input  logic               smiReq,
  input  logic               decReq,
  input  logic [MSR_W-1:0]   msrQ,
  output msrCtl_t            ctl,
  output logic               intTake,
  output logic               wrErr
);
  logic powDiff;
  logic otherDiff;
  logic wrWins;
  logic badWr;

  always_comb begin
    powDiff   = mtData[POW_B] ^ msrQ[POW_B];
    otherDiff = |((mtData ^ msrQ) & ~POW_MASK);
    wrWins    = mtWr && !excTake && !rfi;
    badWr     = wrWins && powDiff && otherDiff;
    ctl.doExc   = excTake;
    ctl.doRfi   = rfi && !excTake;
    ctl.doWr    = wrWins && !badWr;
    ctl.tlbMiss = (excCause == CAUSE_W'(ITLB_CODE)) ||
                  (excCause == CAUSE_W'(DLD_CODE))  ||
                  (excCause == CAUSE_W'(DST_CODE));
  end

  assign intTake = msrQ[EE_B] & (extReq | smiReq | decReq);

  always_ff @(posedge clk) begin
    if (!rstN) wrErr <= 1'b0;
    else       wrErr <= badWr;
  end
endmodule

// File: rtl/msr_dp.sv
module msr_dp
  import msr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  msrCtl_t          ctl,
  input  logic [MSR_W-1:0] mtData,
  output logic [MSR_W-1:0] msrQ,
  output logic [MSR_W-1:0] srrQ
);
  logic [MSR_W-1:0] excNext;
  logic [MSR_W-1:0] rfiNext;

  always_comb begin
    excNext        = msrQ;
    excNext[EE_B]  = 1'b0;
    excNext[PR_B]  = 1'b0;
    excNext[FP_B]  = 1'b0;
    excNext[IR_B]  = 1'b0;
    excNext[DR_B]  = 1'b0;
    excNext[LE_B]  = msrQ[ILE_B];
    if (ctl.tlbMiss) excNext[TGPR_B] = 1'b1;

    rfiNext         = srrQ;
    rfiNext[TGPR_B] = 1'b0;
    rfiNext[POW_B]  = msrQ[POW_B];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msrQ <= RESET_VAL;
      srrQ <= '0;
    end else if (ctl.doExc) begin
      srrQ <= msrQ & SAVE_MASK;
      msrQ <= excNext;
    end else if (ctl.doRfi) begin
      msrQ <= rfiNext;
    end else if (ctl.doWr) begin
      msrQ <= mtData;
    end
  end
endmodule

// File: rtl/msr_exc_ctrl.sv
module msr_exc_ctrl
  import msr_pkg::*;
#(
  parameter int CAUSE_W   = 3,
  parameter int ITLB_CODE = 1,
  parameter int DLD_CODE  = 2,
  parameter int DST_CODE  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               mtWr,
  input  logic [31:0]        mtData,
  input  logic               excTake,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic               rfi,
  input  logic               extReq,
  input  logic               smiReq,
  input  logic               decReq,
  output logic [31:0]        msrQ,
  output logic [31:0]        srrQ,
  output logic               powQ,
  output logic               tgprQ,
  output logic               leQ,
  output logic               eeQ,
  output logic               prQ,
  output logic               irQ,
  output logic               drQ,
  output logic               intTake,
  output logic               wrErr
);
  msrCtl_t ctl;

  msr_ctrl #(
    .CAUSE_W(CAUSE_W), .ITLB_CODE(ITLB_CODE),
    .DLD_CODE(DLD_CODE), .DST_CODE(DST_CODE)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .mtWr(mtWr), .mtData(mtData),
    .excTake(excTake), .excCause(excCause), .rfi(rfi),
    .extReq(extReq), .smiReq(smiReq), .decReq(decReq),
    .msrQ(msrQ), .ctl(ctl), .intTake(intTake), .wrErr(wrErr)
  );

  msr_dp dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mtData(mtData),
    .msrQ(msrQ), .srrQ(srrQ)
  );

  assign powQ  = msrQ[POW_B];
  assign tgprQ = msrQ[TGPR_B];
  assign leQ   = msrQ[LE_B];
  assign eeQ   = msrQ[EE_B];
  assign prQ   = msrQ[PR_B];
  assign irQ   = msrQ[IR_B];
  assign drQ   = msrQ[DR_B];
endmodule

// File: rtl/msr_exc_ctrl_chk.sv
module msr_exc_ctrl_chk
  import msr_pkg::*;
#(
  parameter int CAUSE_W   = 3,
  parameter int ITLB_CODE = 1,
  parameter int DLD_CODE  = 2,
  parameter int DST_CODE  = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               mtWr,
  input logic               excTake,
  input logic [CAUSE_W-1:0] excCause,
  input logic               rfi,
  input logic               extReq,
  input logic               smiReq,
  input logic               decReq,
  input logic [31:0]        msrQ,
  input logic [31:0]        srrQ,
  input logic               powQ,
  input logic               tgprQ,
  input logic               leQ,
  input logic               eeQ,
  input logic               intTake,
  input logic               wrErr
);
  logic isTlb;
  assign isTlb = (excCause == CAUSE_W'(ITLB_CODE)) || (excCause == CAUSE_W'(DLD_CODE)) ||
                 (excCause == CAUSE_W'(DST_CODE));

  a_r3_save_drops_partial: assert property (@(posedge clk) disable iff (!rstN)
    excTake |=> srrQ == ($past(msrQ) & SAVE_MASK));

  a_r4_le_from_ile: assert property (@(posedge clk) disable iff (!rstN)
    excTake |=> leQ == $past(msrQ[ILE_B]) && !eeQ);

  a_r5_tlb_sets_remap: assert property (@(posedge clk) disable iff (!rstN)
    excTake && isTlb |=> tgprQ);

  a_r6_rfi_restore: assert property (@(posedge clk) disable iff (!rstN)
    rfi && !excTake |=> !tgprQ && $stable(srrQ));

  a_r7_gate_off: assert property (@(posedge clk) disable iff (!rstN)
    !eeQ |-> !intTake);

  a_r7_gate_on: assert property (@(posedge clk) disable iff (!rstN)
    eeQ && (extReq || smiReq || decReq) |-> intTake);

  a_r8_reject_keeps_word: assert property (@(posedge clk) disable iff (!rstN)
    wrErr |-> $stable(msrQ));

  a_r10_pow_only_by_write: assert property (@(posedge clk) disable iff (!rstN)
    powQ != $past(powQ) |-> $past(mtWr && !excTake && !rfi));
endmodule

bind msr_exc_ctrl msr_exc_ctrl_chk #(
  .CAUSE_W(CAUSE_W), .ITLB_CODE(ITLB_CODE), .DLD_CODE(DLD_CODE), .DST_CODE(DST_CODE)
) chk_i (
  .clk(clk), .rstN(rstN), .mtWr(mtWr), .excTake(excTake), .excCause(excCause),
  .rfi(rfi), .extReq(extReq), .smiReq(smiReq), .decReq(decReq),
  .msrQ(msrQ), .srrQ(srrQ), .powQ(powQ), .tgprQ(tgprQ), .leQ(leQ), .eeQ(eeQ),
  .intTake(intTake), .wrErr(wrErr)
);

// File: tb/msr_exc_ctrl_tb.sv
module msr_exc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mtWr = 1'b0;
  logic [31:0] mtData = '0;
  logic        excTake = 1'b0;
  logic [2:0]  excCause = '0;
  logic        rfi = 1'b0;
  logic        extReq = 1'b0, smiReq = 1'b0, decReq = 1'b0;
  logic [31:0] msrQ, srrQ;
  logic        powQ, tgprQ, leQ, eeQ, prQ, irQ, drQ, intTake, wrErr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [31:0] mMsr, mSrr;

  always #10 clk = ~clk;

  msr_exc_ctrl dut_i (
    .clk(clk), .rstN(rstN), .mtWr(mtWr), .mtData(mtData), .excTake(excTake),
    .excCause(excCause), .rfi(rfi), .extReq(extReq), .smiReq(smiReq), .decReq(decReq),
    .msrQ(msrQ), .srrQ(srrQ), .powQ(powQ), .tgprQ(tgprQ), .leQ(leQ), .eeQ(eeQ),
    .prQ(prQ), .irQ(irQ), .drQ(drQ), .intTake(intTake), .wrErr(wrErr)
  );

  function automatic int ix(input int n);
    return 31 - n;
  endfunction

  function automatic logic [31:0] saveOf(input logic [31:0] m);
    logic [31:0] r = m;
    for (int n = 1; n <= 4; n++) r[ix(n)] = 1'b0;
    for (int n = 10; n <= 12; n++) r[ix(n)] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] excOf(input logic [31:0] m, input logic [2:0] c);
    logic [31:0] r = m;
    r[ix(16)] = 1'b0; r[ix(17)] = 1'b0; r[ix(18)] = 1'b0;
    r[ix(26)] = 1'b0; r[ix(27)] = 1'b0;
    r[ix(31)] = m[ix(15)];
    if (c >= 3'd1 && c <= 3'd3) r[ix(14)] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] rfiOf(input logic [31:0] s, input logic [31:0] m);
    logic [31:0] r = s;
    r[ix(14)] = 1'b0;
    r[ix(13)] = m[ix(13)];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [31:0] d, input logic e,
                      input logic [2:0] c, input logic r);
    @(negedge clk);
    mtWr = w; mtData = d; excTake = e; excCause = c; rfi = r;
    @(negedge clk);
    mtWr = 1'b0; excTake = 1'b0; rfi = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] p;
    repeat (3) @(negedge clk);
    chk("R1 reset msr", msrQ, 32'h0000_1000);
    chk("R1 reset srr", srrQ, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", msrQ, 32'h0000_1000);
    mMsr = 32'h0000_1000; mSrr = '0;

    // R7: request gating over both enable states
    for (int ee = 0; ee < 2; ee++) begin
      p = ee ? (32'h1 << ix(16)) : 32'h0;
      step(1'b1, p, 1'b0, 3'd0, 1'b0);
      chk("R2 write", msrQ, p);
      for (int q = 0; q < 8; q++) begin
        extReq = q[0]; smiReq = q[1]; decReq = q[2];
        #1;
        chk("R7 intTake", {31'b0, intTake}, {31'b0, (ee == 1) && (q != 0)});
      end
      extReq = 0; smiReq = 0; decReq = 0;
    end
    mMsr = p;

    // R3 R4 R5 R6: patterns x cause codes, entry then return
    for (int i = 0; i < 64; i++) begin
      for (int c = 0; c < 8; c++) begin
        p = (i * 32'h9E37_79B9) ^ (c * 32'h0101_0101) ^ {i[7:0], 24'h5A_3C_00};
        p[ix(13)] = 1'b0;
        step(1'b1, p, 1'b0, 3'd0, 1'b0);
        if (msrQ !== p) chk("R2 pattern write", msrQ, p);
        mMsr = p;
        step(1'b0, '0, 1'b1, c[2:0], 1'b0);
        mSrr = saveOf(mMsr);
        mMsr = excOf(mMsr, c[2:0]);
        chk("R3 save", srrQ, mSrr);
        chk("R4 R5 entry", msrQ, mMsr);
        step(1'b0, '0, 1'b0, 3'd0, 1'b1);
        mMsr = rfiOf(mSrr, mMsr);
        chk("R6 return", msrQ, mMsr);
        if (srrQ !== mSrr) chk("R6 srr kept", srrQ, mSrr);
      end
    end

    // R2 R8 R10: power-mode writes
    p = mMsr ^ (32'h1 << ix(13));
    step(1'b1, p, 1'b0, 3'd0, 1'b0);
    chk("R2 pow only write", msrQ, p);
    chk("R8 no err on good write", {31'b0, wrErr}, 32'h0);
    mMsr = p;
    p = mMsr ^ (32'h1 << ix(13)) ^ 32'h0000_0001;
    step(1'b1, p, 1'b0, 3'd0, 1'b0);
    chk("R8 bad write ignored", msrQ, mMsr);
    chk("R8 err pulse", {31'b0, wrErr}, 32'h1);
    @(negedge clk);
    chk("R8 err one cycle", {31'b0, wrErr}, 32'h0);
    step(1'b0, '0, 1'b1, 3'd5, 1'b0);
    mSrr = saveOf(mMsr); mMsr = excOf(mMsr, 3'd5);
    chk("R10 pow kept on entry", {31'b0, powQ}, 32'h1);
    mSrr[ix(13)] = 1'b1;
    step(1'b1, mMsr ^ (32'h1 << ix(13)), 1'b0, 3'd0, 1'b0);
    mMsr[ix(13)] = 1'b0;
    step(1'b0, '0, 1'b0, 3'd0, 1'b1);
    mMsr = rfiOf(mSrr, mMsr);
    chk("R10 pow kept on return", msrQ, mMsr);

    // R9: collisions
    p = ~mMsr & ~(32'h1 << ix(13));
    p[ix(13)] = mMsr[ix(13)];
    step(1'b1, p, 1'b1, 3'd2, 1'b1);
    mSrr = saveOf(mMsr); mMsr = excOf(mMsr, 3'd2);
    chk("R9 exc beats all", msrQ, mMsr);
    chk("R9 srr on collision", srrQ, mSrr);
    step(1'b1, p, 1'b0, 3'd0, 1'b1);
    mMsr = rfiOf(mSrr, mMsr);
    chk("R9 rfi beats write", msrQ, mMsr);
    p = mMsr ^ 32'hFFFF_FFFF;
    step(1'b1, p, 1'b1, 3'd0, 1'b0);
    mSrr = saveOf(mMsr); mMsr = excOf(mMsr, 3'd0);
    chk("R9 losing bad write state", msrQ, mMsr);
    chk("R9 losing bad write no err", {31'b0, wrErr}, 32'h0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule